// File: doc/BRIEF.md
# Buffered Pulse Train Player

This block turns a list of (level, length) pairs into a waveform on one output wire. A writer on a slow or bursty path loads the pairs one at a time into an internal FIFO. Nothing appears on the output while this happens. When a separate start input rises, a sequencer drains the FIFO at the full clock rate. It drives the output at each entry's level for exactly that entry's length in clock cycles, with no spare cycles between entries.

Reproducible test stimulus is the main use. A fixed pulse train can be loaded once, then fired on command with cycle-exact timing, whatever the pace at which it was loaded. After the last entry the wire goes back to a chosen rest level and a one-cycle completion strobe is raised. The player then waits for the FIFO to be loaded and started again.

Top module: `pulse_seq_gen`

## Requirements
- R1: Entries written while no playback is running produce no output activity. `pulse_out` stays at the rest level and `busy` stays low until `go` rises.
- R2: An entry is `DUR_W+1` bits wide. Bit `DUR_W` is the level to drive and bits `DUR_W-1:0` are the duration in clock cycles. The output holds that level for exactly that many cycles.
- R3: An entry whose duration field is zero is played as one cycle.
- R4: Take the clock edge that first samples `go` high as edge 0. The first entry's level appears on `pulse_out` after edge 2. Every later entry follows the previous one with no idle cycle, including runs of one-cycle entries.
- R5: After the last buffered entry's final cycle, `pulse_out` returns to the `IDLE_LVL` parameter and `done` is high for exactly one cycle. `busy` falls in that same cycle.
- R6: `go` is edge-sensitive. Holding it high starts one playback only, and a rising edge while `busy` is high is ignored.
- R7: `full` is high once `DEPTH` entries are held. A write while `full` is high is discarded and sets `overflow`, which then stays high until reset.
- R8: Synchronous active-high `rst` empties the FIFO, clears `overflow`, `done` and `busy`, and puts `pulse_out` at the rest level. A playback started on an empty FIFO raises `done` after edge 1 and emits no pulse.
- R9: `busy` is high from the cycle after edge 0 until the cycle in which `done` is raised.
- R10: Entries are played in the order they were written, and each entry is played only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | DUR_W+1 | Entry to store: level in the top bit, duration below it |
| wr_en | input | 1 | Write strobe for `wr_data` |
| full | output | 1 | FIFO holds DEPTH entries |
| overflow | output | 1 | Sticky flag: a write was dropped because the FIFO was full |
| go | input | 1 | Start request, acted on at its rising edge |
| pulse_out | output | 1 | Generated pulse train |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle strobe at the end of playback |

## Verification
The corner that is hardest to reach is a chain of one-cycle entries. There the next entry must come straight from the RAM read register in the very cycle it is needed, with no time to pass through the prefetch slot first. The stimulus plays a run of one-cycle and zero-duration entries, and also a FIFO filled to exactly `DEPTH` one-cycle entries with one extra write that must be dropped. The bench then compares `pulse_out` against the expected waveform on every cycle. A gap, a repeated entry or an accepted overflow write each shifts that waveform visibly.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  // Sequencer phases: idle, armed (waiting for an entry), playing an entry
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ARM  = 2'd1,
    PS_PLAY = 2'd2
  } pseq_state_e;

endpackage

// File: rtl/pseq_fifo.sv
module pseq_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             overflow,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             ovf_q;
  logic             wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ok    = wr_en && !full;
  assign rd_ok    = rd_en && !empty;
  assign overflow = ovf_q;

  // Storage without reset so that a block RAM with registered read fits
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
    if (rd_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) rptr <= bump(rptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) ovf_q <= 1'b1;
    end
  end

  // R7
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> overflow);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R10
  no_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

endmodule

// File: rtl/pseq_sequencer.sv
module pseq_sequencer
  import pseq_pkg::*;
#(
  parameter int   DUR_W    = 16,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         fifo_empty,
  input  logic [DUR_W:0] rd_data,
  output logic         rd_en,
  output logic         pulse_out,
  output logic         busy,
  output logic         done
);

  pseq_state_e      state;
  logic [DUR_W-1:0] cnt;
  logic [DUR_W:0]   nxt_q;
  logic             nxt_vld, rd_pend;
  logic             out_q, done_q;

  logic             avail, boundary, take, finish;
  logic [DUR_W:0]   head;
  logic [DUR_W-1:0] head_dur, load_cnt;

  // One prefetched entry lives either in the RAM read register or the slot
  assign avail    = nxt_vld | rd_pend;
  assign head     = nxt_vld ? nxt_q : rd_data;
  assign head_dur = head[DUR_W-1:0];
  assign load_cnt = (head_dur == '0) ? DUR_W'(1) : head_dur;

  assign boundary = (state == PS_ARM) || (state == PS_PLAY && cnt == DUR_W'(1));
  assign take     = boundary && avail;
  assign finish   = boundary && !avail && fifo_empty;
  assign rd_en    = (state != PS_IDLE) && !fifo_empty && (!avail || take);

  assign pulse_out = out_q;
  assign done      = done_q;
  assign busy      = (state != PS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_IDLE;
      cnt     <= '0;
      nxt_q   <= '0;
      nxt_vld <= 1'b0;
      rd_pend <= 1'b0;
      out_q   <= IDLE_LVL;
      done_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      rd_pend <= rd_en;
      if (take) begin
        nxt_vld <= 1'b0;
      end else if (rd_pend) begin
        nxt_q   <= rd_data;
        nxt_vld <= 1'b1;
      end
      case (state)
        PS_IDLE: begin
          if (start) state <= PS_ARM;
        end
        default: begin
          if (take) begin
            out_q <= head[DUR_W];
            cnt   <= load_cnt;
            state <= PS_PLAY;
          end else if (finish) begin
            out_q  <= IDLE_LVL;
            done_q <= 1'b1;
            state  <= PS_IDLE;
          end else if (state == PS_PLAY) begin
            if (cnt == DUR_W'(1)) begin
              out_q <= IDLE_LVL;
              state <= PS_ARM;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_rest_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pulse_out == IDLE_LVL) && !busy);

  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PS_PLAY && cnt > DUR_W'(1)) |=> $stable(pulse_out));

  // R3
  count_live_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PS_PLAY) |-> (cnt != '0));

  // R4
  one_prefetch_chk: assert property (@(posedge clk) disable iff (rst)
    !(nxt_vld && rd_pend));

endmodule

// File: rtl/pulse_seq_gen.sv
module pulse_seq_gen #(
  parameter int   DEPTH    = 64,
  parameter int   DUR_W    = 16,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DUR_W:0] wr_data,
  input  logic           wr_en,
  output logic           full,
  output logic           overflow,
  input  logic           go,
  output logic           pulse_out,
  output logic           busy,
  output logic           done
);

  localparam int ENTRY_W = DUR_W + 1;

  logic               go_q, start;
  logic               rd_en, fifo_empty;
  logic [ENTRY_W-1:0] rd_data;

  always_ff @(posedge clk) begin
    if (rst) go_q <= 1'b0;
    else     go_q <= go;
  end

  assign start = go && !go_q && !busy;

  pseq_fifo #(
    .DEPTH (DEPTH),
    .WIDTH (ENTRY_W)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .full     (full),
    .overflow (overflow),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .empty    (fifo_empty)
  );

  pseq_sequencer #(
    .DUR_W    (DUR_W),
    .IDLE_LVL (IDLE_LVL)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .fifo_empty (fifo_empty),
    .rd_data    (rd_data),
    .rd_en      (rd_en),
    .pulse_out  (pulse_out),
    .busy       (busy),
    .done       (done)
  );

  // R6
  busy_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (pulse_out == IDLE_LVL));

endmodule

// File: tb/sim_pulse_seq_gen.sv
module sim_pulse_seq_gen;

  localparam int   DEPTH = 64;
  localparam int   DUR_W = 16;
  localparam logic IDLE  = 1'b0;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [DUR_W:0] wr_data = '0;
  logic           wr_en = 1'b0;
  logic           go = 1'b0;
  logic           full, overflow, pulse_out, busy, done;

  int checks = 0;
  int errors = 0;

  logic ent_lv [0:127];
  int   ent_du [0:127];
  int   n_ent = 0;

  always #10 clk = ~clk;

  pulse_seq_gen #(.DEPTH(DEPTH), .DUR_W(DUR_W), .IDLE_LVL(IDLE)) u0 (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en), .full(full),
    .overflow(overflow), .go(go), .pulse_out(pulse_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic lv, input int du, input bit keep);
    wr_data = {lv, DUR_W'(du)};
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    if (keep) begin
      ent_lv[n_ent] = lv;
      ent_du[n_ent] = du;
      n_ent++;
    end
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic logic exp_out(input int j);
    int acc = 2;
    if (j < 2) return IDLE;
    for (int i = 0; i < n_ent; i++) begin
      if (j < acc + eff(ent_du[i])) return ent_lv[i];
      acc += eff(ent_du[i]);
    end
    return IDLE;
  endfunction

  // Cycle index j is the negedge after edge j, edge 0 being the one sampling go
  task automatic play(input string req, input bit hold_go, input int low_at,
                      input int high_at);
    int total = 0;
    int fin;
    int tail;
    for (int i = 0; i < n_ent; i++) total += eff(ent_du[i]);
    fin  = (n_ent == 0) ? 1 : 2 + total;
    tail = hold_go ? 25 : 4;
    go = 1'b1;
    @(negedge clk);
    if (!hold_go) go = 1'b0;
    for (int j = 0; j <= fin + tail; j++) begin
      chk(pulse_out === exp_out(j), req, $sformatf("pulse_out at cycle %0d", j),
          int'(pulse_out), int'(exp_out(j)));
      chk(busy === (j < fin), req, $sformatf("busy at cycle %0d", j),
          int'(busy), int'(j < fin));
      chk(done === (j == fin), req, $sformatf("done at cycle %0d", j),
          int'(done), int'(j == fin));
      if (hold_go && j == low_at)  go = 1'b0;
      if (hold_go && j == high_at) go = 1'b1;
      @(negedge clk);
    end
    go    = 1'b0;
    n_ent = 0;
  endtask

  task automatic t_reset_state;
    chk(pulse_out === IDLE, "R8", "pulse_out after reset", int'(pulse_out), int'(IDLE));
    chk(busy === 1'b0, "R8", "busy after reset", int'(busy), 0);
    chk(done === 1'b0, "R8", "done after reset", int'(done), 0);
    chk(full === 1'b0, "R8", "full after reset", int'(full), 0);
    chk(overflow === 1'b0, "R8", "overflow after reset", int'(overflow), 0);
  endtask

  task automatic t_load_then_play;
    push(1'b1, 3, 1'b1);
    repeat (5) @(negedge clk);
    push(1'b0, 2, 1'b1);
    push(1'b1, 5, 1'b1);
    for (int k = 0; k < 20; k++) begin
      chk(pulse_out === IDLE && busy === 1'b0, "R1",
          $sformatf("quiet before go, cycle %0d", k), int'({busy, pulse_out}), 0);
      @(negedge clk);
    end
    play("R2 R4 R5 R9 R10", 1'b0, 0, 0);
  endtask

  task automatic t_short_entries;
    push(1'b1, 1, 1'b1);
    push(1'b0, 1, 1'b1);
    push(1'b1, 0, 1'b1);   // R3: zero duration plays one cycle
    push(1'b1, 1, 1'b1);
    push(1'b0, 0, 1'b1);
    push(1'b1, 2, 1'b1);
    push(1'b1, 1, 1'b1);
    play("R3 R4", 1'b0, 0, 0);
  endtask

  task automatic t_go_levels;
    push(1'b1, 20, 1'b1);
    push(1'b0, 4, 1'b1);
    // R6: go held, dropped at cycle 5, raised again at cycle 8 while busy
    play("R6", 1'b1, 5, 8);
  endtask

  task automatic t_full_overflow;
    for (int i = 0; i < DEPTH; i++) push(i[0] ? 1'b0 : 1'b1, 1, 1'b1);
    chk(full === 1'b1, "R7", "full at DEPTH entries", int'(full), 1);
    chk(overflow === 1'b0, "R7", "overflow before extra write", int'(overflow), 0);
    push(1'b1, 50, 1'b0);
    chk(overflow === 1'b1, "R7", "overflow after write while full", int'(overflow), 1);
    chk(full === 1'b1, "R7", "still full after dropped write", int'(full), 1);
    play("R7 R4", 1'b0, 0, 0);
    chk(full === 1'b0, "R7", "full after drain", int'(full), 0);
    chk(overflow === 1'b1, "R7", "overflow sticky after drain", int'(overflow), 1);
  endtask

  task automatic t_reset_clears;
    push(1'b1, 7, 1'b0);
    push(1'b0, 3, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(overflow === 1'b0, "R8", "overflow cleared by reset", int'(overflow), 0);
    chk(busy === 1'b0, "R8", "busy cleared by reset", int'(busy), 0);
    chk(pulse_out === IDLE, "R8", "pulse_out after second reset", int'(pulse_out), int'(IDLE));
    play("R8", 1'b0, 0, 0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_load_then_play();
    t_short_entries();
    t_go_levels();
    t_full_overflow();
    t_reset_clears();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1-wide watchdog: run hung actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

endmodule